// File: doc/BRIEF.md
# Programmable Pulse Train Generator

This block drives a single output pin with a burst of equal pulses, or with one long pulse. A 32-bit configuration word sets the shape of the pulses. Its low half is the length of one base period in clock cycles. Its high half is a threshold that splits each period into a high part and a low part. Writing a 32-bit count word starts the burst at once; no separate start command exists. The count is the number of periods in pulse mode, or the number of clocks in one-shot mode.

Inside each period a down-counter runs from the period length to 1. The output is high while that counter is above the threshold. The count drops by one at the end of each period, and the down-counter reloads only while count remains. A threshold of zero selects one-shot mode. In that mode the period logic is bypassed and the output stays high for exactly as many clocks as the count, with single-clock resolution across the full 32 bits.

Software writes the configuration while the enable is low, then raises the enable, then writes the count. Dropping the enable stops all activity and clears the counters.

Top module: `pulse_train_gen`

## Requirements
- R1: While `en` is low, `pulse_out` is low. One clock after any edge that samples `en` low, `busy` is low and both counters are cleared.
- R2: A write on `cfg_wr` is stored only when `en` is low. While `en` is high the stored configuration does not change, and later bursts use the old value.
- R3: A write on `cnt_wr` with `en` high loads `cnt_data` and starts a burst. The down-counter loads the period at the same edge, and `busy` is high from the next cycle when `cnt_data` is nonzero. Count writes while `en` is low are ignored.
- R4: In pulse mode (threshold `cfg[31:16]` nonzero), each period lasts P = `cfg[15:0]` cycles. During the period the down-counter takes the values P, P-1, ..., 1, and `pulse_out` is high while that value is greater than the threshold.
- R5: In pulse mode the count drops by one at the end of each period, so a burst of count N lasts N*P cycles. After that, `busy` and `pulse_out` are low and the down-counter holds at zero.
- R6: In one-shot mode (threshold zero), the count drops by one every clock, and `pulse_out` is high for exactly N consecutive cycles after a write of N, whatever the period field holds.
- R7: `busy` is high exactly when the count is nonzero, and `pulse_out` is never high while `busy` is low.
- R8: A count write during a burst discards the remaining activity and restarts from the new value at the start of a fresh period.
- R9: When the threshold is greater than or equal to P in pulse mode, `pulse_out` stays low for the whole N*P-cycle burst, while `busy` stays high.
- R10: Writing a count of zero with `en` high ends any burst: `busy` and `pulse_out` are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low clears counters and accepts configuration |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Configuration: [31:16] threshold, [15:0] period |
| cnt_wr | input | 1 | Count write strobe; starts a burst |
| cnt_data | input | 32 | Count value |
| busy | output | 1 | High while the count is nonzero |
| pulse_out | output | 1 | Pulse output |

## Verification
The bench sweeps every period from 1 to 5, every threshold from 0 to 5 and counts of 1 to 3. This covers the split between pulse mode and one-shot mode, and thresholds at, above and below the period. A design that compared with the wrong sign or off by one would make each high part one cycle too long or too short. A design that reloaded the period after the last one would stay busy for one period too many. A design with a one-shot that still decremented per period would hold the pulse P times too long; a long one-shot case catches the same fault across many clocks. A restart in mid-burst, a zero write, a configuration write while enabled, and a drop of the enable in mid-burst are each checked. A design that merged state across a restart, or took configuration while running, would shift or reshape the output.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    parameter int CNT_W  = 32;
    parameter int HALF_W = 16;

    typedef struct packed {
        logic [HALF_W-1:0] thresh;
        logic [HALF_W-1:0] period;
    } cfg_t;

    function automatic logic is_one_shot(input cfg_t c);
        return (c.thresh == '0);
    endfunction

endpackage

// File: rtl/ptg_cfg_reg.sv
module ptg_cfg_reg
    import ptg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr,
    input  logic [CNT_W-1:0] data,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (wr && !en)
            cfg <= cfg_t'(data);
    end

endmodule

// File: rtl/ptg_period_ctr.sv
module ptg_period_ctr
    import ptg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  cfg_t              cfg,
    input  logic              running,
    input  logic              last_unit,
    output logic [HALF_W-1:0] per_cnt,
    output logic              per_done
);

    assign per_done = (per_cnt <= HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            per_cnt <= '0;
        end else if (start) begin
            per_cnt <= cfg.period;
        end else if (running && !is_one_shot(cfg)) begin
            if (per_done)
                per_cnt <= last_unit ? '0 : cfg.period;
            else
                per_cnt <= per_cnt - HALF_W'(1);
        end
    end

endmodule

// File: rtl/ptg_unit_cnt.sv
module ptg_unit_cnt
    import ptg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    input  logic             one_shot,
    input  logic             per_done,
    output logic [CNT_W-1:0] units,
    output logic             running,
    output logic             last_unit
);

    assign running   = (units != '0);
    assign last_unit = (units == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            units <= '0;
        else if (start)
            units <= load_val;
        else if (running && (one_shot || per_done))
            units <= units - CNT_W'(1);
    end

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
    import ptg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_data,
    input  logic        cnt_wr,
    input  logic [31:0] cnt_data,
    output logic        busy,
    output logic        pulse_out
);

    cfg_t              cfg;
    logic [HALF_W-1:0] per_cnt;
    logic              per_done;
    logic [CNT_W-1:0]  units;
    logic              running;
    logic              last_unit;
    logic              start;
    logic              one_shot;

    assign start    = en && cnt_wr;
    assign one_shot = is_one_shot(cfg);

    ptg_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .wr   (cfg_wr),
        .data (cfg_data),
        .cfg  (cfg)
    );

    ptg_period_ctr u_per (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .start     (start),
        .cfg       (cfg),
        .running   (running),
        .last_unit (last_unit),
        .per_cnt   (per_cnt),
        .per_done  (per_done)
    );

    ptg_unit_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .start     (start),
        .load_val  (cnt_data),
        .one_shot  (one_shot),
        .per_done  (per_done),
        .units     (units),
        .running   (running),
        .last_unit (last_unit)
    );

    assign busy      = running;
    assign pulse_out = en && running && (one_shot || (per_cnt > cfg.thresh));

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
    import ptg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        cfg_wr,
    input logic        cnt_wr,
    input logic [31:0] cnt_data,
    input logic        busy,
    input logic        pulse_out,
    input cfg_t        cfg
);

    // R1
    dis_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pulse_out);

    // R1
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(cfg));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_wr && cnt_data != 32'd0) |=> busy);

    // R10
    cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_wr && cnt_data == 32'd0) |=> !busy);

    // R7
    out_busy_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> busy);

    // R6
    one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        (en && busy && cfg.thresh == '0) |-> pulse_out);

endmodule

bind pulse_train_gen ptg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cfg_wr    (cfg_wr),
    .cnt_wr    (cnt_wr),
    .cnt_data  (cnt_data),
    .busy      (busy),
    .pulse_out (pulse_out),
    .cfg       (cfg)
);

// File: tb/pulse_train_gen_test.sv
module pulse_train_gen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        cfg_wr;
    logic [31:0] cfg_data;
    logic        cnt_wr;
    logic [31:0] cnt_data;
    logic        busy;
    logic        pulse_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pulse_train_gen uut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .cfg_wr    (cfg_wr),
        .cfg_data  (cfg_data),
        .cnt_wr    (cnt_wr),
        .cnt_data  (cnt_data),
        .busy      (busy),
        .pulse_out (pulse_out)
    );

    task automatic check(input string req, input logic act_o, input logic exp_o,
                         input logic act_b, input logic exp_b);
        total++;
        if (act_o !== exp_o || act_b !== exp_b) begin
            bad++;
            $display("FAIL %s: out=%b busy=%b expected out=%b busy=%b at %0t",
                     req, act_o, act_b, exp_o, exp_b, $time);
        end
    endtask

    task automatic set_cfg(input int per, input int thr);
        en = 1'b0;
        cfg_data = {16'(thr), 16'(per)};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_cnt(input int n);
        cnt_data = 32'(n);
        cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    // Observe a full burst starting from the cycle after the count write.
    task automatic run_burst(input string req, input int per, input int thr, input int n);
        int dur;
        dur = (thr == 0) ? n : n * per;
        for (int i = 0; i < dur + 2; i++) begin
            logic eo, eb;
            eb = (i < dur);
            if (thr == 0) eo = eb;
            else          eo = eb && ((per - (i % per)) > thr);
            check(req, pulse_out, eo, busy, eb);
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; cfg_wr = 1'b0; cnt_wr = 1'b0;
        cfg_data = '0; cnt_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", pulse_out, 1'b0, busy, 1'b0);

        // R3: count write while disabled is ignored
        cnt_data = 32'd5; cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
        check("R3 write while disabled", pulse_out, 1'b0, busy, 1'b0);

        // R4 R5 R6 R9: sweep period, threshold, count
        for (int per = 1; per <= 5; per++)
            for (int thr = 0; thr <= 5; thr++)
                for (int n = 1; n <= 3; n++) begin
                    set_cfg(per, thr);
                    write_cnt(n);
                    if (thr == 0)        run_burst("R6 one-shot", per, thr, n);
                    else if (thr >= per) run_burst("R9 low burst", per, thr, n);
                    else                 run_burst("R4 R5 pulse", per, thr, n);
                end

        // R6: long one-shot
        set_cfg(7, 0);
        write_cnt(5000);
        run_burst("R6 long one-shot", 7, 0, 5000);

        // R8: restart in mid burst
        set_cfg(4, 1);
        write_cnt(3);
        repeat (5) @(negedge clk);
        write_cnt(2);
        run_burst("R8 restart", 4, 1, 2);

        // R10: zero write stops a burst
        write_cnt(3);
        repeat (3) @(negedge clk);
        write_cnt(0);
        check("R10 zero write", pulse_out, 1'b0, busy, 1'b0);

        // R2: config write while enabled is ignored
        cfg_data = {16'd0, 16'd2}; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        write_cnt(2);
        run_burst("R2 config held", 4, 1, 2);

        // R1: dropping enable mid burst
        write_cnt(3);
        @(negedge clk);
        check("R1 active before drop", pulse_out, 1'b1, busy, 1'b1);
        en = 1'b0;
        #1;
        check("R1 out low on drop", pulse_out, 1'b0, busy, 1'b1);
        @(negedge clk);
        check("R1 cleared", pulse_out, 1'b0, busy, 1'b0);
        en = 1'b1;
        @(negedge clk);
        check("R1 R7 stays idle", pulse_out, 1'b0, busy, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule